// File: doc/BRIEF.md
# Parallel Sampling-Converter Read Controller

This block runs in the host clock domain and drives a 12-bit parallel-output sampling converter. The converter is used in the mode where the host controls conversion start and data read separately. The controller produces three active-low strobes: convert-start, read and chip-select. It watches the converter's active-low end-of-conversion output through a synchronizer. When a result is pending and the acquisition gap has passed, it lowers all three strobes together. That single window reads the finished result and starts the next conversion. The very first start after power-up, and the start after a lost conversion, lower only the convert-start strobe.

Every timing limit is a parameter counted in host clock cycles. These limits cover the start pulse width, the data-access wait, the acquisition gap, the power-up wait and the end-of-conversion timeout. The power-up wait is fourteen converter clocks plus the acquisition time plus a reference-settling term. Results enter a small internal FIFO, and the consumer drains it through a valid/ready stream. A half-full flag serves as the consumer's interrupt. When the FIFO is full, the next read-and-start is held back, so no sample is dropped. Each stalled result increments a saturating counter.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset is released, all three strobes stay high for 14*CLK_DIV + ACQ_CYC + SETTLE_CYC host cycles. The first convert-start falls exactly at the end of that wait.
- R2: Every convert-start low pulse lasts at least CNV_LO_CYC host cycles.
- R3: Read and chip-select fall only in the same cycle as convert-start. Together they stay low for max(CNV_LO_CYC, ACCESS_CYC+1) cycles. The data bus is captured on the last of those cycles.
- R4: The first start after reset, and the first start after a timeout, lower convert-start alone, with read and chip-select held high.
- R5: A start is not issued until at least ACQ_CYC cycles after the end-of-conversion input has fallen.
- R6: Captured words leave on s_data in conversion order, unmodified, as 12-bit two's complement (0x800 = -2048, 0x7FF = +2047, 0xFFF = -1). s_data holds steady while s_valid is high and s_ready is low.
- R7: While the FIFO holds DEPTH words and a result is pending, no further start or read is issued. That result is delivered later, so no sample is lost.
- R8: The overflow counter increments once for each pending result that is stalled by a full FIFO. It never decreases and it saturates.
- R9: half_full is 1 exactly when the FIFO holds at least DEPTH/2 words.
- R10: If the end-of-conversion input does not fall within TIMEOUT_CYC cycles of a start, timeout_err is set and stays set until reset. The controller then waits the acquisition gap and starts again.
- R11: During reset all strobes are high, and s_valid, half_full, timeout_err and the overflow count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_cnv_n | output | 1 | Convert-start strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_cs_n | output | 1 | Chip-select strobe, active low |
| adc_eoc_n | input | 1 | Converter end-of-conversion flag, falls when a result is ready |
| adc_data | input | DW | Converter data bus |
| s_valid | output | 1 | Stream word available |
| s_ready | input | 1 | Consumer accepts the word |
| s_data | output | DW | Stream word, two's complement |
| half_full | output | 1 | FIFO holds at least half its depth |
| timeout_err | output | 1 | Sticky end-of-conversion timeout flag |
| ovf_count | output | OVF_W | Saturating count of results stalled by a full FIFO |

## Verification
The assertions assume that the end-of-conversion input falls only while a conversion is in progress, and that it returns high only after a read strobe. The bench's converter model follows both rules. Its conversion time is shorter than the timeout, so every timeout comes from a deliberately suppressed conversion. The model drives valid data only after the read strobes have been low for a settled number of cycles. The consumer asserts s_ready only after it has seen a word, so the bench can check every word and back-pressure arises only where a test asks for it.

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DW          = 12,
  parameter int CLK_DIV     = 13,
  parameter int CNV_LO_CYC  = 3,
  parameter int ACCESS_CYC  = 10,
  parameter int ACQ_CYC     = 35,
  parameter int SETTLE_CYC  = 1_100_000,
  parameter int TIMEOUT_CYC = 16*CLK_DIV + 16,
  parameter int DEPTH       = 8,
  parameter int OVF_W       = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  output logic             adc_cnv_n,
  output logic             adc_rd_n,
  output logic             adc_cs_n,
  input  logic             adc_eoc_n,
  input  logic [DW-1:0]    adc_data,
  output logic             s_valid,
  input  logic             s_ready,
  output logic [DW-1:0]    s_data,
  output logic             half_full,
  output logic             timeout_err,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int PWR_CYC = 14*CLK_DIV + ACQ_CYC + SETTLE_CYC;
  localparam int STR_CYC = (CNV_LO_CYC > ACCESS_CYC+1) ? CNV_LO_CYC : ACCESS_CYC+1;
  localparam int M1      = (PWR_CYC > TIMEOUT_CYC) ? PWR_CYC : TIMEOUT_CYC;
  localparam int M2      = (STR_CYC > ACQ_CYC) ? STR_CYC : ACQ_CYC;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CW      = $clog2(CNT_MAX+1);
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {ST_PWR, ST_START, ST_CONV, ST_GAP} st_t;

  st_t            st, nxt;
  logic [CW-1:0]  cnt;
  logic [2:0]     eoc_sh;
  logic           pend, stall;
  logic           eoc_fall, gap_done, full, push, pop;
  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [AW:0]    level;

  assign eoc_fall  = eoc_sh[2] & ~eoc_sh[1];
  assign gap_done  = cnt >= CW'(ACQ_CYC-1);
  assign full      = level == (AW+1)'(DEPTH);
  assign push      = (st == ST_START) && pend && (cnt == CW'(STR_CYC-1));
  assign pop       = s_valid & s_ready;
  assign s_valid   = level != '0;
  assign s_data    = mem[rp];
  assign half_full = level >= (AW+1)'(DEPTH/2);

  always_comb begin
    nxt = st;
    case (st)
      ST_PWR:   if (cnt == CW'(PWR_CYC-1)) nxt = ST_START;
      ST_START: if (cnt == CW'(STR_CYC-1)) nxt = ST_CONV;
      ST_CONV:  if (eoc_fall || cnt == CW'(TIMEOUT_CYC-1)) nxt = ST_GAP;
      ST_GAP:   if (gap_done && !(pend && full)) nxt = ST_START;
      default:  nxt = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_PWR;
      cnt         <= '0;
      eoc_sh      <= '1;
      pend        <= 1'b0;
      stall       <= 1'b0;
      adc_cnv_n   <= 1'b1;
      adc_rd_n    <= 1'b1;
      adc_cs_n    <= 1'b1;
      timeout_err <= 1'b0;
      ovf_count   <= '0;
    end else begin
      st     <= nxt;
      eoc_sh <= {eoc_sh[1:0], adc_eoc_n};
      if (nxt != st)                cnt <= '0;
      else if (cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;

      if (st == ST_CONV && eoc_fall) pend <= 1'b1;
      else if (push)                 pend <= 1'b0;

      adc_cnv_n <= !(nxt == ST_START);
      adc_rd_n  <= !(nxt == ST_START && pend);
      adc_cs_n  <= !(nxt == ST_START && pend);

      if (st == ST_CONV && !eoc_fall && cnt == CW'(TIMEOUT_CYC-1))
        timeout_err <= 1'b1;

      if (st == ST_GAP && gap_done && pend && full && !stall) begin
        stall <= 1'b1;
        if (ovf_count != '1) ovf_count <= ovf_count + 1'b1;
      end else if (nxt != ST_GAP) begin
        stall <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= adc_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int DW         = 12,
  parameter int CNV_LO_CYC = 3,
  parameter int ACQ_CYC    = 35,
  parameter int PWR_CYC    = 100,
  parameter int DEPTH      = 8,
  parameter int OVF_W      = 8,
  parameter int LW         = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_n,
  input logic             rd_n,
  input logic             cs_n,
  input logic             eoc_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic [DW-1:0]    s_data,
  input logic             err,
  input logic [OVF_W-1:0] ovf,
  input logic [LW-1:0]    level
);
  int   since, lo, gap;
  logic eoc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= 0;
      lo    <= 0;
      gap   <= ACQ_CYC;
      eoc_q <= 1'b1;
    end else begin
      if (since < PWR_CYC) since <= since + 1;
      lo    <= cnv_n ? 0 : ((lo < CNV_LO_CYC) ? lo + 1 : lo);
      eoc_q <= eoc_n;
      if (eoc_q && !eoc_n)   gap <= 0;
      else if (gap < ACQ_CYC) gap <= gap + 1;
    end
  end

  p_pwr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since < PWR_CYC) |-> (cnv_n && rd_n && cs_n));
  p_cnv_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n) |-> (lo >= CNV_LO_CYC));
  p_read_with_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($fell(cnv_n) && $fell(cs_n)));
  p_acq_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> (gap >= ACQ_CYC));
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_data)));
  p_no_start_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cnv_n) && !rd_n) |-> (level < LW'(DEPTH)));
  p_ovf_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> (ovf >= $past(ovf)));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .DW(DW), .CNV_LO_CYC(CNV_LO_CYC), .ACQ_CYC(ACQ_CYC),
  .PWR_CYC(14*CLK_DIV + ACQ_CYC + SETTLE_CYC), .DEPTH(DEPTH), .OVF_W(OVF_W),
  .LW(((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_n(adc_cnv_n), .rd_n(adc_rd_n), .cs_n(adc_cs_n),
  .eoc_n(adc_eoc_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
  .err(timeout_err), .ovf(ovf_count), .level(level)
);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  localparam int CLK_DIV = 13, CNV_LO = 3, ACC = 10, ACQ = 35, SETTLE = 20, DEPTH = 8;
  localparam int PWR      = 14*CLK_DIV + ACQ + SETTLE;
  localparam int CONV_CYC = 14*CLK_DIV;

  // {code, expected signed value}
  localparam logic [27:0] VEC [16] = '{
    {12'h000, 16'sd0},     {12'h7FF, 16'sd2047},  {12'h800, -16'sd2048}, {12'hFFF, -16'sd1},
    {12'h001, 16'sd1},     {12'h400, 16'sd1024},  {12'hC00, -16'sd1024}, {12'h123, 16'sd291},
    {12'hEDC, -16'sd292},  {12'h555, 16'sd1365},  {12'hAAA, -16'sd1366}, {12'h7FE, 16'sd2046},
    {12'h801, -16'sd2047}, {12'h0F0, 16'sd240},   {12'hF10, -16'sd240},  {12'h3E8, 16'sd1000}
  };

  logic clk = 1'b0, rst_n = 1'b0, s_ready = 1'b0, eoc_n = 1'b1;
  logic cnv_n, rd_n, cs_n, s_valid, half_full, err;
  logic [11:0] adc_d = 12'h5A5, s_data;
  logic [7:0]  ovf;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.CLK_DIV(CLK_DIV), .CNV_LO_CYC(CNV_LO), .ACCESS_CYC(ACC), .ACQ_CYC(ACQ),
                .SETTLE_CYC(SETTLE), .DEPTH(DEPTH)) u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_cnv_n(cnv_n), .adc_rd_n(rd_n), .adc_cs_n(cs_n),
    .adc_eoc_n(eoc_n), .adc_data(adc_d), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .half_full(half_full), .timeout_err(err), .ovf_count(ovf));

  int checks = 0, errors = 0;
  int idx, ccnt, rdlow, cyc, first_start, alone, reads, lo_run, min_lo, gap, min_gap, last_start, bad_rd;
  bit busy, sup_cur, suppress, p_cnv, p_rd;
  logic [11:0] result;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model, updated away from the active edge
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      busy = 0; eoc_n = 1; idx = 0; cyc = 0; first_start = -1; alone = 0; reads = 0;
      lo_run = 0; min_lo = 1000000; gap = 1000000; min_gap = 1000000; bad_rd = 0;
      rdlow = 0; adc_d = 12'h5A5; p_cnv = 1; p_rd = 1; suppress = 0; last_start = 0;
      continue;
    end
    cyc++; gap++;
    if (!cnv_n) lo_run++;
    if (p_cnv && !cnv_n) begin
      if (first_start < 0) first_start = cyc;
      if (gap < min_gap) min_gap = gap;
      last_start = cyc;
      if (rd_n) alone++;
      busy = 1; ccnt = CONV_CYC; sup_cur = suppress; suppress = 0;
    end
    if (!p_cnv && cnv_n) begin
      if (lo_run < min_lo) min_lo = lo_run;
      lo_run = 0;
    end
    if (p_rd && !rd_n) begin
      reads++;
      if (cs_n || cnv_n || !p_cnv) bad_rd++;
      eoc_n = 1;
    end
    if (!rd_n && !cs_n) rdlow++; else rdlow = 0;
    adc_d = (rdlow >= 8) ? result : 12'h5A5;
    if (busy) begin
      ccnt--;
      if (ccnt == 0) begin
        busy = 0;
        if (!sup_cur) begin
          result = VEC[idx % 16][27:16]; idx++; eoc_n = 0; gap = 0;
        end
      end
    end
    p_cnv = cnv_n; p_rd = rd_n;
  end

  task automatic do_reset();
    rst_n = 0; s_ready = 0;
    repeat (5) @(negedge clk);
    chk(cnv_n && rd_n && cs_n, "R11 strobes high in reset", {cnv_n, rd_n, cs_n}, 7);
    chk(!s_valid && !half_full, "R11 stream idle in reset", {s_valid, half_full}, 0);
    chk(!err && ovf == 0, "R11 flags clear in reset", {err, ovf}, 0);
    rst_n = 1;
  endtask

  task automatic take(input int k);
    @(negedge clk);
    while (!s_valid) @(negedge clk);
    chk(s_data == VEC[k % 16][27:16] && $signed(s_data) == $signed(VEC[k % 16][15:0]),
        "R6 sample order/value", int'($signed(s_data)), int'($signed(VEC[k % 16][15:0])));
    s_ready = 1;
    @(negedge clk);
    s_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10 watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    for (int k = 0; k < 16; k++) take(k);
    chk(first_start == PWR, "R1 power-up wait", first_start, PWR);
    chk(alone == 1, "R4 first start alone", alone, 1);
    chk(min_lo >= CNV_LO, "R2 start width", min_lo, CNV_LO);
    chk(bad_rd == 0, "R3 read only with start", bad_rd, 0);
    chk(min_gap >= ACQ, "R5 acquisition gap", min_gap, ACQ);

    do_reset();
    while (reads < 3) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(half_full == 0, "R9 three words below half", half_full, 0);
    chk(ovf == 0, "R8 no stall yet", ovf, 0);
    while (reads < 4) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(half_full == 1, "R9 four words at half", half_full, 1);
    while (reads < 8) @(negedge clk);
    repeat (1500) @(negedge clk);
    chk(reads == 8, "R7 no read while full", reads, 8);
    chk(cyc - last_start >= 1400, "R7 start held off", cyc - last_start, 1400);
    chk(ovf == 1, "R8 one stalled result", ovf, 1);
    for (int k = 0; k < 12; k++) take(k);
    chk(ovf == 1, "R8 counter kept", ovf, 1);
    chk(err == 0, "R10 no timeout yet", err, 0);

    suppress = 1;
    for (int k = 12; k < 20; k++) take(k);
    repeat (400) @(negedge clk);
    chk(err == 1, "R10 timeout flagged", err, 1);
    for (int k = 20; k < 24; k++) take(k);
    chk(err == 1, "R10 timeout sticky", err, 1);
    chk(alone == 2, "R4 restart alone after timeout", alone, 2);
    chk(bad_rd == 0 && min_gap >= ACQ, "R3 R5 after timeout", bad_rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule